// File: doc/BRIEF.md
# Sleep-Time Wakeup Pin Monitor

This block watches a parameterised set of input pins while the chip sleeps and raises a single wake request when a programmed event appears on an enabled pin. Software sets up each pin through a small word-addressed register port. Each pin gets an enable bit, a rising-edge arm, a falling-edge arm and a level polarity. Before sleep, software clears the status words. It then asserts the sleep input. After waking, it reads the status words and ANDs them with the enables to find which pins caused the wakeup.

Every pin passes through a two-flop synchronizer. A third flop holds the previous synchronized sample, which is what edge detection compares against. A pin with either edge arm set is edge-triggered. A pin with neither edge arm set is level-triggered, and its polarity bit chooses the active level. The register map starts with two general-purpose timer words. After them come five banks in a fixed order, each one word wide per 32 pins.

The read port returns one response word for each read strobe. The response is valid for exactly one cycle and there is no back-pressure: the requester must accept the word in the cycle `rsp_valid` is high. Writes complete in the cycle they are presented.

Top module: `wake_monitor`

## Requirements
- R1: After reset, every timer, enable, rising, falling, polarity and status word reads zero, and `wake_o` is low.
- R2: With W = ceil(NUM_PINS/32), the timer words sit at byte offsets 0x00 and 0x04 and are plain read/write storage. Bank g, word i sits at byte offset (g*W + i + 2)*4, with bank order g = 0 enable, 1 falling, 2 rising, 3 polarity, 4 status.
- R3: Pin p maps to word p/32, bit p%32 of every bank. A write replaces the whole word. Bits at or above NUM_PINS ignore writes and read zero.
- R4: A pin with only its rising arm set latches on a low-to-high change of its synchronized input, and not on a high-to-low change.
- R5: A pin with only its falling arm set latches on a high-to-low change, and not on a low-to-high change.
- R6: A pin with both arms set latches on either change.
- R7: A pin with neither arm set is level-triggered. It latches in every cycle its input equals its polarity bit (1 means active-high, 0 means active-low).
- R8: Status bits are set by pin events only while `sleep_i` is high.
- R9: A disabled pin never sets its status bit and never causes `wake_o`. A status bit written to 1 on a disabled pin does not raise `wake_o`.
- R10: Status bits are sticky until software writes their word. A write loads the written value, and it takes priority over an event arriving in the same cycle.
- R11: `wake_o` is a registered OR over all (status AND enable) bits. It rises one cycle after a qualifying status bit is set and falls one cycle after the last such bit is cleared.
- R12: Reads at word addresses at or beyond 2 + 5*W return zero. Writes there change nothing.
- R13: A read strobe in one cycle gives `rsp_valid` high with the data in the next cycle, and for nothing else.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address; bits [1:0] ignored |
| bus_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response valid, one cycle after `bus_rd` |
| rsp_data | output | 32 | Read response word |
| pin_i | input | NUM_PINS | Asynchronous wakeup pins |
| sleep_i | input | 1 | High while the system sleeps; gates status latching |
| wake_o | output | 1 | Wake request |

## Verification
A single set of pins is configured with one pin in each trigger flavour: rise-only, fall-only, both edges, active-high level and active-low level. One extra enabled pin sits in the second word, and one armed pin is left disabled. Each pin is toggled in both directions. This separates arm decoding (for example, a fall on a rise-only pin must leave status clear) and checks the per-pin bit position. Clearing a word while a level pin stays active must relatch at once, while clearing after an edge must not. The same toggles are repeated with sleep low and must set nothing. Direct status writes on a disabled bit show that pending is masked by enable. Reading back the distinct configuration patterns confirms the bank order and the out-of-range behaviour.

// File: rtl/wkm_pkg.sv
package wkm_pkg;
  localparam int NUM_GRP = 5;
  localparam int NUM_TMR = 2;

  typedef enum logic [2:0] {
    GRP_EN   = 3'd0,
    GRP_FALL = 3'd1,
    GRP_RISE = 3'd2,
    GRP_POL  = 3'd3,
    GRP_STAT = 3'd4
  } grp_e;

  function automatic int words_for(input int pins);
    return (pins + 31) / 32;
  endfunction
endpackage

// File: rtl/wkm_sync.sv
module wkm_sync #(
  parameter int WIDTH = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] cur_o,
  output logic [WIDTH-1:0] prev_o
);
  for (genvar p = 0; p < WIDTH; p++) begin : g_bit
    logic meta_q, cur_q, prev_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        cur_q  <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        meta_q <= pin_i[p];
        cur_q  <= meta_q;
        prev_q <= cur_q;
      end
    end
    assign cur_o[p]  = cur_q;
    assign prev_o[p] = prev_q;
  end
endmodule

// File: rtl/wkm_detect.sv
module wkm_detect #(
  parameter int WIDTH = 40
) (
  input  logic [WIDTH-1:0] cur_i,
  input  logic [WIDTH-1:0] prev_i,
  input  logic [WIDTH-1:0] rise_sel_i,
  input  logic [WIDTH-1:0] fall_sel_i,
  input  logic [WIDTH-1:0] pol_i,
  output logic [WIDTH-1:0] hit_o
);
  for (genvar p = 0; p < WIDTH; p++) begin : g_pin
    logic went_up, went_down, edge_mode;
    assign went_up   = cur_i[p] & ~prev_i[p];
    assign went_down = ~cur_i[p] & prev_i[p];
    assign edge_mode = rise_sel_i[p] | fall_sel_i[p];
    assign hit_o[p]  = edge_mode ? ((rise_sel_i[p] & went_up) | (fall_sel_i[p] & went_down))
                                 : (cur_i[p] == pol_i[p]);
  end
endmodule

// File: rtl/wkm_regs.sv
module wkm_regs
  import wkm_pkg::*;
#(
  parameter int NUM_PINS = 40,
  parameter int ADDR_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_i,
  input  logic                rd_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [31:0]         wdata_i,
  input  logic [NUM_PINS-1:0] hit_i,
  input  logic                sleep_i,
  output logic                rvalid_o,
  output logic [31:0]         rdata_o,
  output logic [NUM_PINS-1:0] en_o,
  output logic [NUM_PINS-1:0] rise_o,
  output logic [NUM_PINS-1:0] fall_o,
  output logic [NUM_PINS-1:0] pol_o,
  output logic [NUM_PINS-1:0] stat_o
);
  localparam int WORDS = words_for(NUM_PINS);
  localparam int PADW  = WORDS * 32;
  localparam int LASTW = NUM_TMR + NUM_GRP * WORDS;

  function automatic logic [PADW-1:0] impl_mask();
    logic [PADW-1:0] m;
    m = '0;
    for (int b = 0; b < NUM_PINS; b++) m[b] = 1'b1;
    return m;
  endfunction
  localparam logic [PADW-1:0] IMPL = impl_mask();

  logic [PADW-1:0]   bank_q [NUM_GRP];
  logic [31:0]       tmr_q  [NUM_TMR];
  logic [ADDR_W-3:0] waddr;
  logic [PADW-1:0]   hit_pad;
  logic [31:0]       rd_word;

  assign waddr   = addr_i[ADDR_W-1:2];
  assign hit_pad = PADW'(hit_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int g = 0; g < NUM_GRP; g++) bank_q[g] <= '0;
      for (int t = 0; t < NUM_TMR; t++) tmr_q[t] <= '0;
    end else begin
      bank_q[GRP_STAT] <= bank_q[GRP_STAT] | (hit_pad & bank_q[GRP_EN] & {PADW{sleep_i}});
      for (int t = 0; t < NUM_TMR; t++)
        if (wr_i && int'(waddr) == t) tmr_q[t] <= wdata_i;
      for (int g = 0; g < NUM_GRP; g++)
        for (int i = 0; i < WORDS; i++)
          if (wr_i && int'(waddr) == NUM_TMR + g * WORDS + i)
            bank_q[g][i*32 +: 32] <= wdata_i & IMPL[i*32 +: 32];
    end
  end

  always_comb begin
    rd_word = '0;
    for (int t = 0; t < NUM_TMR; t++)
      if (int'(waddr) == t) rd_word = tmr_q[t];
    for (int g = 0; g < NUM_GRP; g++)
      for (int i = 0; i < WORDS; i++)
        if (int'(waddr) == NUM_TMR + g * WORDS + i) rd_word = bank_q[g][i*32 +: 32];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= rd_i;
      if (rd_i) rdata_o <= rd_word;
    end
  end

  assign en_o   = bank_q[GRP_EN][NUM_PINS-1:0];
  assign rise_o = bank_q[GRP_RISE][NUM_PINS-1:0];
  assign fall_o = bank_q[GRP_FALL][NUM_PINS-1:0];
  assign pol_o  = bank_q[GRP_POL][NUM_PINS-1:0];
  assign stat_o = bank_q[GRP_STAT][NUM_PINS-1:0];

  // R8
  stat_awake_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep_i && !wr_i) |=> $stable(bank_q[GRP_STAT]));
  // R10
  stat_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_i) |=> ((bank_q[GRP_STAT] & $past(bank_q[GRP_STAT])) == $past(bank_q[GRP_STAT])));
  // R9
  stat_disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_i) |=> ((bank_q[GRP_STAT] & ~$past(bank_q[GRP_STAT]) & ~$past(bank_q[GRP_EN])) == '0));
  // R12
  oob_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && int'(waddr) >= LASTW) |=> (rdata_o == '0));
  // R13
  rsp_follows_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_i |=> rvalid_o);
  // R13
  rsp_only_on_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_i |=> !rvalid_o);
endmodule

// File: rtl/wake_monitor.sv
module wake_monitor #(
  parameter int NUM_PINS = 40,
  parameter int ADDR_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic                rsp_valid,
  output logic [31:0]         rsp_data,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic                sleep_i,
  output logic                wake_o
);
  logic [NUM_PINS-1:0] cur, prev, hit, en, rise, fall, pol, stat, pending;

  wkm_sync #(.WIDTH(NUM_PINS)) i_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .cur_o(cur), .prev_o(prev)
  );

  wkm_detect #(.WIDTH(NUM_PINS)) i_detect (
    .cur_i(cur), .prev_i(prev), .rise_sel_i(rise), .fall_sel_i(fall),
    .pol_i(pol), .hit_o(hit)
  );

  wkm_regs #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) i_regs (
    .clk(clk), .rst_n(rst_n), .wr_i(bus_wr), .rd_i(bus_rd), .addr_i(bus_addr),
    .wdata_i(bus_wdata), .hit_i(hit), .sleep_i(sleep_i), .rvalid_o(rsp_valid),
    .rdata_o(rsp_data), .en_o(en), .rise_o(rise), .fall_o(fall), .pol_o(pol),
    .stat_o(stat)
  );

  assign pending = stat & en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wake_o <= 1'b0;
    else        wake_o <= |pending;
  end

  // R11
  wake_needs_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> $past(|pending));
  // R11
  wake_follows_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|pending) |=> wake_o);
  // R4
  rise_only_no_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise[0] && !fall[0] && !cur[0] && prev[0]) |-> !hit[0]);
endmodule

// File: tb/test_wake_monitor.sv
`timescale 1ns/1ps
module test_wake_monitor;
  localparam int N = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic [N-1:0] pins = '0;
  logic        sleep = 1'b0;
  logic        wake;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  wake_monitor #(.NUM_PINS(N), .ADDR_W(8)) i_wake_monitor (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .pin_i(pins), .sleep_i(sleep), .wake_o(wake)
  );

  // byte offsets: bank g word i at (g*2+i+2)*4
  localparam logic [7:0] A_T0 = 8'h00, A_T1 = 8'h04, A_EN0 = 8'h08, A_EN1 = 8'h0C,
    A_FA0 = 8'h10, A_RI0 = 8'h18, A_RI1 = 8'h1C, A_PO0 = 8'h20,
    A_ST0 = 8'h28, A_ST1 = 8'h2C, A_OOB = 8'h30;

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic pin(input int idx, input logic v);
    @(negedge clk); pins[idx] = v;
    repeat (5) @(negedge clk);
  endtask

  task automatic chk_wake(input logic e, input string tag);
    checks++;
    if (wake !== e) begin
      errors++;
      $display("FAIL %s: wake actual=%0b expected=%0b", tag, wake, e);
    end
  endtask

  // monitor: pops expected responses as the design returns them (R13)
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R13: unexpected response actual=%08h expected=none", rsp_data);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rsp_data !== e) begin
          errors++;
          $display("FAIL %s: read actual=%08h expected=%08h", t, rsp_data, e);
        end
      end
    end
  end

  initial begin
    pins[1] = 1'b1; pins[3] = 1'b1; pins[4] = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk_wake(1'b0, "R1");
    for (int w = 0; w < 12; w++) rd(8'(w * 4), 32'h0, "R1");

    // R2 timers and bank order
    wr(A_T1, 32'hDEADBEEF);
    rd(A_T1, 32'hDEADBEEF, "R2");
    rd(A_T0, 32'h0, "R2");
    wr(A_EN0, 32'h0000001F);
    wr(A_EN1, 32'hFFFFFFFF);
    rd(A_EN1, 32'h000000FF, "R3");   // bits 40..63 unimplemented
    wr(A_EN1, 32'h00000008);          // pin 35
    wr(A_RI0, 32'h00000025);          // pins 0,2,5
    wr(A_RI1, 32'h00000008);          // pin 35
    wr(A_FA0, 32'h00000006);          // pins 1,2
    wr(A_PO0, 32'h00000008);          // pin 3 active-high
    rd(A_RI0, 32'h25, "R2");
    rd(A_FA0, 32'h06, "R2");
    rd(A_PO0, 32'h08, "R2");
    rd(A_EN0, 32'h1F, "R2");

    // R12 out of range
    wr(A_OOB, 32'h12345678);
    rd(A_OOB, 32'h0, "R12");
    rd(8'h34, 32'h0, "R12");
    rd(A_EN0, 32'h1F, "R12");
    rd(A_T0, 32'h0, "R12");

    // awake: active level on pin 3 must not latch (R8)
    repeat (5) @(negedge clk);
    rd(A_ST0, 32'h0, "R8");
    pin(3, 1'b0);
    wr(A_ST0, 32'h0);
    @(negedge clk); sleep = 1'b1;
    repeat (5) @(negedge clk);
    rd(A_ST0, 32'h0, "R7");
    rd(A_ST1, 32'h0, "R7");
    chk_wake(1'b0, "R11");

    pin(0, 1'b1);
    rd(A_ST0, 32'h01, "R4");
    chk_wake(1'b1, "R11");
    pin(5, 1'b1);
    rd(A_ST0, 32'h01, "R9");
    pin(0, 1'b0);
    rd(A_ST0, 32'h01, "R10");
    pin(1, 1'b0);
    rd(A_ST0, 32'h03, "R5");
    wr(A_ST0, 32'h0);
    repeat (3) @(negedge clk);
    chk_wake(1'b0, "R11");
    rd(A_ST0, 32'h0, "R10");

    pin(2, 1'b1);
    rd(A_ST0, 32'h04, "R6");
    wr(A_ST0, 32'h0);
    pin(2, 1'b0);
    rd(A_ST0, 32'h04, "R6");
    wr(A_ST0, 32'h0);

    pin(0, 1'b1);
    wr(A_ST0, 32'h0);
    pin(0, 1'b0);
    rd(A_ST0, 32'h0, "R4");
    pin(1, 1'b1);
    rd(A_ST0, 32'h0, "R5");

    pin(3, 1'b1);
    rd(A_ST0, 32'h08, "R7");
    wr(A_ST0, 32'h0);
    rd(A_ST0, 32'h08, "R7");   // level still active: relatches
    pin(3, 1'b0);
    wr(A_ST0, 32'h0);
    pin(4, 1'b0);
    rd(A_ST0, 32'h10, "R7");
    pin(4, 1'b1);
    wr(A_ST0, 32'h0);
    rd(A_ST0, 32'h0, "R7");

    pin(35, 1'b1);
    rd(A_ST1, 32'h08, "R3");
    rd(A_ST0, 32'h0, "R3");
    chk_wake(1'b1, "R11");
    wr(A_ST1, 32'h0);
    repeat (3) @(negedge clk);
    chk_wake(1'b0, "R11");

    // awake again: nothing latches (R8)
    @(negedge clk); sleep = 1'b0;
    pin(0, 1'b1);
    pin(3, 1'b1);
    rd(A_ST0, 32'h0, "R8");
    rd(A_ST1, 32'h0, "R8");

    // direct load on a disabled bit (R10, R9)
    wr(A_ST0, 32'h40);
    rd(A_ST0, 32'h40, "R10");
    repeat (3) @(negedge clk);
    chk_wake(1'b0, "R9");

    repeat (4) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R13: missing responses actual=%0d expected=0", exp_q.size());
    end
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(5.0 * 50000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule